// File: doc/BRIEF.md
# Byte-Beat Pixel Assembler

This block rebuilds full-width pixels for a parallel RGB panel from a pixel source that delivers them in beats. Three modes are supported. In the first, each 16-bit beat is already a whole RGB565 pixel. In the second, a pixel arrives as two byte beats. In the third, a 24-bit RGB888 pixel arrives as three byte beats. Byte beats arrive most significant byte first on the low byte of the beat bus. A line-start strobe, aligned with the panel's sync, puts the beat position back to the start of a pixel. A software-set swap option exchanges the red and blue positions in the incoming word.

Every pixel leaves the block with a fixed latency per mode. The latency is counted from the pixel's first beat when its beats arrive back to back, and it must match the first-pixel correction that the timing generator applies. The 16-bit pixels are widened to 6 bits per colour by copying each field's top bits into its missing low bits. They are presented left-aligned on 8-bit colour outputs.

Top module: `pix_beat_asm`

## Requirements
- R1: While reset is asserted and after it is released, `px_valid` is low until a pixel has been assembled.
- R2: With `cfg_mode` = 0 (whole 16-bit beats), every beat with `beat_valid` high gives a pixel with `px_valid` high in the same cycle, built from `beat_data[15:0]`.
- R3: With `cfg_mode` = 1 (two byte beats), the pixel word is {first beat[7:0], second beat[7:0]}. `beat_data[15:8]` is ignored. `px_valid` rises 3 cycles after the first beat when the two beats come in consecutive cycles.
- R4: With `cfg_mode` = 2 (three byte beats), the pixel word is {beat0[7:0], beat1[7:0], beat2[7:0]}. `px_valid` rises 5 cycles after the first beat when the beats come in consecutive cycles.
- R5: In modes 0 and 1 with `cfg_bgr` = 0, the word's bits 15:11 are red, bits 10:5 are green and bits 4:0 are blue. Each output is the 6-bit value in bits 7:2, and bits 1:0 are zero. A 5-bit field f becomes {f, f[4]}.
- R6: In mode 2 with `cfg_bgr` = 0, the word's bits 23:16 are red, bits 15:8 are green and bits 7:0 are blue, passed through unchanged.
- R7: With `cfg_bgr` = 1, the red and blue fields trade places: red is taken from bits 4:0 (16-bit word) or 7:0 (24-bit word), and blue from bits 15:11 or 23:16.
- R8: A beat with `line_start` high is always the first beat of a new pixel. Any partly received pixel is dropped.
- R9: `cfg_mode` = 3 is reserved: beats are ignored and `px_valid` stays low.
- R10: Cycles without `beat_valid` do not advance the beat position. A pixel whose beats are spread out appears 0, 2 or 3 cycles (modes 0, 1, 2) after the cycle of its final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0: whole 16-bit beats, 1: two byte beats, 2: three byte beats, 3: reserved |
| cfg_bgr | input | 1 | Swap red and blue field positions |
| line_start | input | 1 | Marks the current beat as the first beat of a pixel |
| beat_valid | input | 1 | A beat is present on `beat_data` |
| beat_data | input | 16 | Beat payload; byte modes use bits 7:0 |
| px_valid | output | 1 | A pixel is present on the colour outputs |
| px_r | output | 8 | Red component |
| px_g | output | 8 | Green component |
| px_b | output | 8 | Blue component |

## Verification
The assertions check the timing on every cycle. A whole-word beat gives an immediate pixel, and reserved mode stays silent. In each byte mode, every output pixel must sit exactly the mode's delay after a beat. The 6-bit colour encoding must hold on every 16-bit pixel. The field mapping, the byte order, the red-blue swap, the dropping of a partial pixel on a line start, and the gapped-beat timing can only be shown by the bench's scenarios: random beat streams in each mode and swap setting, plus directed patterns whose expected colours are computed from the requirements.

// File: rtl/pba_pkg.sv
package pba_pkg;

   typedef enum logic [1:0] {
      MODE_WIDE16 = 2'd0,
      MODE_B565   = 2'd1,
      MODE_B888   = 2'd2,
      MODE_OFF    = 2'd3
   } pix_mode_e;

   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } rgb_t;

endpackage

// File: rtl/pba_collect.sv
// Beat position tracking and byte accumulation, most significant byte first.
module pba_collect
   import pba_pkg::*;
#(
   parameter int BEAT_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  pix_mode_e             mode,
   input  logic                  line_start,
   input  logic                  beat_valid,
   input  logic [2*BEAT_W-1:0]   beat_data,
   output logic                  word_valid,
   output logic [3*BEAT_W-1:0]   word
);

   localparam int ACC_W = 2 * BEAT_W;

   logic [1:0]        cnt;
   logic [1:0]        idx;
   logic [1:0]        last_idx;
   logic              active;
   logic [ACC_W-1:0]  acc;
   logic [BEAT_W-1:0] byte_in;

   assign byte_in = beat_data[BEAT_W-1:0];
   assign active  = (mode != MODE_OFF);
   assign idx     = line_start ? 2'd0 : cnt;

   always_comb begin
      unique case (mode)
         MODE_B565: last_idx = 2'd1;
         MODE_B888: last_idx = 2'd2;
         default:   last_idx = 2'd0;
      endcase
   end

   assign word_valid = beat_valid && active && (idx == last_idx);

   always_comb begin
      unique case (mode)
         MODE_WIDE16: word = {{BEAT_W{1'b0}}, beat_data};
         MODE_B565:   word = {{BEAT_W{1'b0}}, acc[BEAT_W-1:0], byte_in};
         MODE_B888:   word = {acc, byte_in};
         default:     word = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= 2'd0;
         acc <= '0;
      end else if (beat_valid && active) begin
         acc <= {acc[BEAT_W-1:0], byte_in};
         cnt <= word_valid ? 2'd0 : 2'(idx + 2'd1);
      end else if (line_start || !active) begin
         cnt <= 2'd0;
      end
   end

endmodule

// File: rtl/pba_unpack.sv
// Field extraction, red/blue swap and 5/6-bit widening.
module pba_unpack
   import pba_pkg::*;
#(
   parameter int BEAT_W = 8
) (
   input  pix_mode_e           mode,
   input  logic                bgr,
   input  logic [3*BEAT_W-1:0] word,
   output rgb_t                pix
);

   function automatic logic [7:0] widen5(input logic [4:0] f);
      return {f, f[4], 2'b00};
   endfunction

   logic [4:0] hi5;
   logic [5:0] mid6;
   logic [4:0] lo5;

   assign hi5  = word[15:11];
   assign mid6 = word[10:5];
   assign lo5  = word[4:0];

   always_comb begin
      if (mode == MODE_B888) begin
         pix.g = word[15:8];
         pix.r = bgr ? word[7:0]   : word[23:16];
         pix.b = bgr ? word[23:16] : word[7:0];
      end else begin
         pix.g = {mid6, 2'b00};
         pix.r = widen5(bgr ? lo5 : hi5);
         pix.b = widen5(bgr ? hi5 : lo5);
      end
   end

endmodule

// File: rtl/pba_align.sv
// Per-mode delay so that every pixel leaves with its mode's fixed latency.
module pba_align
   import pba_pkg::*;
#(
   parameter int MAXD = 3,
   parameter int D565 = 2,
   parameter int D888 = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pix_mode_e mode,
   input  logic      in_valid,
   input  rgb_t      in_pix,
   output logic      out_valid,
   output rgb_t      out_pix
);

   localparam int SEL_W = $clog2(MAXD + 1);

   logic [MAXD:1]   sv;
   rgb_t [MAXD:1]   sp;
   logic [MAXD:0]   tv;
   rgb_t [MAXD:0]   tp;
   logic [SEL_W-1:0] sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sv <= '0;
         sp <= '0;
      end else begin
         sv[1] <= in_valid;
         sp[1] <= in_pix;
         for (int k = 2; k <= MAXD; k++) begin
            sv[k] <= sv[k-1];
            sp[k] <= sp[k-1];
         end
      end
   end

   assign tv = {sv, in_valid};
   assign tp = {sp, in_pix};

   always_comb begin
      unique case (mode)
         MODE_B565: sel = SEL_W'(D565);
         MODE_B888: sel = SEL_W'(D888);
         default:   sel = '0;
      endcase
   end

   assign out_valid = tv[sel];
   assign out_pix   = tp[sel];

endmodule

// File: rtl/pix_beat_asm.sv
module pix_beat_asm
   import pba_pkg::*;
#(
   parameter int BEAT_W  = 8,
   parameter int LAT_565 = 3,
   parameter int LAT_888 = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_mode,
   input  logic                cfg_bgr,
   input  logic                line_start,
   input  logic                beat_valid,
   input  logic [2*BEAT_W-1:0] beat_data,
   output logic                px_valid,
   output logic [7:0]          px_r,
   output logic [7:0]          px_g,
   output logic [7:0]          px_b
);

   localparam int D565 = LAT_565 - 1;
   localparam int D888 = LAT_888 - 2;
   localparam int MAXD = (D565 > D888) ? D565 : D888;

   if (BEAT_W != 8) begin : g_bad_beat
      $error("BEAT_W must be 8 for the RGB565/RGB888 field layout");
   end
   if (LAT_565 < 1 || LAT_888 < 2) begin : g_bad_lat
      $error("latency shorter than the beat count of the mode");
   end
   if (MAXD < 1) begin : g_bad_depth
      $error("at least one byte mode needs an extra delay stage");
   end

   pix_mode_e           mode_e;
   logic                w_valid;
   logic [3*BEAT_W-1:0] w_word;
   rgb_t                w_pix;
   rgb_t                o_pix;

   assign mode_e = pix_mode_e'(cfg_mode);

   pba_collect #(.BEAT_W(BEAT_W)) u_collect (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode_e),
      .line_start (line_start),
      .beat_valid (beat_valid),
      .beat_data  (beat_data),
      .word_valid (w_valid),
      .word       (w_word)
   );

   pba_unpack #(.BEAT_W(BEAT_W)) u_unpack (
      .mode (mode_e),
      .bgr  (cfg_bgr),
      .word (w_word),
      .pix  (w_pix)
   );

   pba_align #(.MAXD(MAXD), .D565(D565), .D888(D888)) u_align (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_e),
      .in_valid  (w_valid),
      .in_pix    (w_pix),
      .out_valid (px_valid),
      .out_pix   (o_pix)
   );

   assign px_r = o_pix.r;
   assign px_g = o_pix.g;
   assign px_b = o_pix.b;

endmodule

// File: rtl/pix_beat_asm_chk.sv
module pix_beat_asm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_mode,
   input logic       beat_valid,
   input logic       px_valid,
   input logic [7:0] px_r,
   input logic [7:0] px_g,
   input logic [7:0] px_b
);

   p_wide_same_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd0 && beat_valid) |-> px_valid);

   p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd3) |-> !px_valid);

   p_lat_565_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (px_valid && cfg_mode == 2'd1 && $past(cfg_mode) == 2'd1 && $past(cfg_mode, 2) == 2'd1)
      |-> $past(beat_valid, 2));

   p_lat_888_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (px_valid && cfg_mode == 2'd2 && $past(cfg_mode) == 2'd2 && $past(cfg_mode, 2) == 2'd2
       && $past(cfg_mode, 3) == 2'd2)
      |-> $past(beat_valid, 3));

   p_widen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (px_valid && (cfg_mode == 2'd0 || cfg_mode == 2'd1) && $past(cfg_mode) == cfg_mode
       && $past(cfg_mode, 2) == cfg_mode && $past(cfg_mode, 3) == cfg_mode)
      |-> (px_r[1:0] == 2'b00 && px_g[1:0] == 2'b00 && px_b[1:0] == 2'b00
           && px_r[2] == px_r[7] && px_b[2] == px_b[7]));

endmodule

bind pix_beat_asm pix_beat_asm_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_mode   (cfg_mode),
   .beat_valid (beat_valid),
   .px_valid   (px_valid),
   .px_r       (px_r),
   .px_g       (px_g),
   .px_b       (px_b)
);

// File: tb/sim_pix_beat_asm.sv
module sim_pix_beat_asm;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_mode = 2'd0;
   logic        cfg_bgr = 1'b0;
   logic        line_start = 1'b0;
   logic        beat_valid = 1'b0;
   logic [15:0] beat_data = 16'h0;
   logic        px_valid;
   logic [7:0]  px_r, px_g, px_b;

   pix_beat_asm u0 (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_bgr(cfg_bgr),
      .line_start(line_start), .beat_valid(beat_valid), .beat_data(beat_data),
      .px_valid(px_valid), .px_r(px_r), .px_g(px_g), .px_b(px_b)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int offv = 0;

   int          due_q[$];
   logic [23:0] val_q[$];
   string       tag_q[$];

   int          m_idx = 0;
   logic [15:0] m_acc = 16'h0;
   string       force_tag = "";

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 60000) begin
         chk(1'b0, "watchdog", 32'(cyc), 32'd60000);
         finish_run();
      end
   end

   function automatic logic [23:0] exp_pix(input int m, input bit bg, input logic [23:0] w);
      logic [7:0] r, g, b;
      logic [4:0] f_hi, f_lo, rr, bb;
      if (m == 2) begin
         g = w[15:8];
         r = bg ? w[7:0] : w[23:16];
         b = bg ? w[23:16] : w[7:0];
      end else begin
         f_hi = w[15:11];
         f_lo = w[4:0];
         rr = bg ? f_lo : f_hi;
         bb = bg ? f_hi : f_lo;
         r = {rr, rr[4], 2'b00};
         g = {w[10:5], 2'b00};
         b = {bb, bb[4], 2'b00};
      end
      return {r, g, b};
   endfunction

   // Monitor: compares every output pixel with the queued expectation.
   always @(negedge clk) begin
      if (rst_n) begin
         while (due_q.size() > 0 && due_q[0] < cyc) begin
            chk(1'b0, tag_q[0], 32'h0, {8'(due_q[0]), val_q[0]});
            void'(due_q.pop_front()); void'(val_q.pop_front()); void'(tag_q.pop_front());
         end
         if (px_valid && cfg_mode == 2'd3) offv++;
         if (px_valid) begin
            if (due_q.size() == 0 || due_q[0] != cyc) begin
               chk(1'b0, (cfg_mode == 2'd3) ? "R9" : "R2", {8'(cyc), px_r, px_g, px_b}, 32'h0);
            end else begin
               chk({px_r, px_g, px_b} == val_q[0], tag_q[0], {8'(cyc), px_r, px_g, px_b},
                   {8'(due_q[0]), val_q[0]});
               void'(due_q.pop_front()); void'(val_q.pop_front()); void'(tag_q.pop_front());
            end
         end
      end
   end

   task automatic idle();
      @(posedge clk); #1;
      beat_valid = 1'b0;
      line_start = 1'b0;
   endtask

   task automatic beat(input logic [15:0] d, input bit ls);
      int bpp, extra;
      logic [23:0] w;
      string t;
      @(posedge clk); #1;
      beat_valid = 1'b1;
      line_start = ls;
      beat_data  = d;
      if (cfg_mode == 2'd3) return;
      bpp   = (cfg_mode == 2'd0) ? 1 : ((cfg_mode == 2'd1) ? 2 : 3);
      extra = (cfg_mode == 2'd0) ? 0 : ((cfg_mode == 2'd1) ? 2 : 3);
      if (ls) m_idx = 0;
      if (cfg_mode == 2'd0) w = {8'h0, d};
      else if (cfg_mode == 2'd1) w = {8'h0, m_acc[7:0], d[7:0]};
      else w = {m_acc, d[7:0]};
      m_acc = {m_acc[7:0], d[7:0]};
      if (m_idx == bpp - 1) begin
         if (force_tag != "") t = force_tag;
         else if (cfg_bgr) t = "R7";
         else if (cfg_mode == 2'd0) t = "R2";
         else if (cfg_mode == 2'd1) t = "R3";
         else t = "R4";
         due_q.push_back(cyc + extra);
         val_q.push_back(exp_pix(int'(cfg_mode), cfg_bgr, w));
         tag_q.push_back(t);
         m_idx = 0;
      end else begin
         m_idx++;
      end
   endtask

   task automatic set_mode(input logic [1:0] m, input bit bg);
      for (int i = 0; i < 6; i++) idle();
      cfg_mode = m;
      cfg_bgr  = bg;
      m_idx    = 0;
   endtask

   task automatic run_rand(input logic [1:0] m, input bit bg, input int npix);
      int bpp;
      set_mode(m, bg);
      bpp = (m == 2'd0) ? 1 : ((m == 2'd1) ? 2 : 3);
      for (int p = 0; p < npix; p++) begin
         bit ls;
         ls = (p == 0) || ($urandom % 8 == 0);
         for (int b = 0; b < bpp; b++) begin
            if (b > 0 && $urandom % 4 == 0) idle();
            beat(16'($urandom), ls && (b == 0));
         end
         if ($urandom % 5 == 0) idle();
      end
      for (int i = 0; i < 8; i++) idle();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(px_valid == 1'b0, "R1", 32'(px_valid), 32'h0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      cfg_mode = 2'd1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(px_valid == 1'b0, "R1", 32'(px_valid), 32'h0);
      end

      // R5: 16-bit field layout and widening (byte mode, bytes F8 1F then 07 E0)
      force_tag = "R5";
      set_mode(2'd1, 1'b0);
      beat(16'h00F8, 1'b1); beat(16'h001F, 1'b0);
      beat(16'h9907, 1'b0); beat(16'h66E0, 1'b0);
      for (int i = 0; i < 6; i++) idle();

      // R6: 24-bit layout, bytes 12 34 56
      force_tag = "R6";
      set_mode(2'd2, 1'b0);
      beat(16'h0012, 1'b1); beat(16'h0034, 1'b0); beat(16'h0056, 1'b0);
      for (int i = 0; i < 6; i++) idle();

      // R7: swap in 24-bit mode, bytes 11 22 33
      force_tag = "R7";
      set_mode(2'd2, 1'b1);
      beat(16'h0011, 1'b1); beat(16'h0022, 1'b0); beat(16'h0033, 1'b0);
      for (int i = 0; i < 6; i++) idle();

      // R8: line start in the middle of a pixel drops the partial bytes
      force_tag = "R8";
      set_mode(2'd2, 1'b0);
      beat(16'h00AA, 1'b1); beat(16'h00BB, 1'b0);
      beat(16'h00C1, 1'b1); beat(16'h00D2, 1'b0); beat(16'h00E3, 1'b0);
      set_mode(2'd1, 1'b0);
      beat(16'h00F0, 1'b1);
      beat(16'h0081, 1'b1); beat(16'h0042, 1'b0);
      for (int i = 0; i < 6; i++) idle();

      // R10: gaps between beats of one pixel
      force_tag = "R10";
      set_mode(2'd1, 1'b0);
      beat(16'h00A5, 1'b1); idle(); idle(); idle(); beat(16'h005A, 1'b0);
      set_mode(2'd2, 1'b1);
      beat(16'h0077, 1'b1); idle(); beat(16'h0088, 1'b0); idle(); idle(); beat(16'h0099, 1'b0);
      for (int i = 0; i < 6; i++) idle();

      // R9: reserved mode gives no pixels
      force_tag = "R9";
      set_mode(2'd3, 1'b0);
      offv = 0;
      for (int i = 0; i < 12; i++) beat(16'($urandom), (i % 3) == 0);
      for (int i = 0; i < 6; i++) idle();
      chk(offv == 0, "R9", 32'(offv), 32'h0);

      // Random streams in every mode and swap setting (R2, R3, R4, R7)
      force_tag = "";
      for (int m = 0; m < 3; m++) begin
         for (int bg = 0; bg < 2; bg++) begin
            run_rand(2'(m), bg[0], 40);
         end
      end

      for (int i = 0; i < 8; i++) idle();
      chk(due_q.size() == 0, "R2", 32'(due_q.size()), 32'h0);
      finish_run();
   end

endmodule